// File: doc/BRIEF.md
# Integer ALU with Shifter

A purely combinational execution unit for a three-operand load/store RISC pipeline. Each cycle it receives two data operands, a separate shift count and a 4-bit operation code. It returns one data result and a flag that is high when that result is all zeros. The flag feeds equal and not-equal branch decisions.

Selection of register or immediate operands, sign or zero extension of immediates, and overflow trapping all happen upstream or downstream of this unit. Add and subtract therefore simply wrap. One adder serves add, subtract and both less-than comparisons. One right-shifting barrel network serves all three shifts: a left shift is done by mirroring the operand on the way in and on the way out.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (add) returns A + B modulo 2^W. No carry or overflow output exists.
- R2: Operation code 1 (subtract) returns A - B modulo 2^W.
- R3: Operation code 2 returns A AND B. Operation code 3 returns A OR B.
- R4: Operation code 4 returns NOT(A OR B). With B all zeros this yields the bitwise complement of A.
- R5: Operation codes 5 and 6 shift A left and right, respectively, by the shift count input (0 to W-1). Vacated bit positions are filled with zeros.
- R6: Operation code 7 shifts A right by the shift count and fills the vacated upper bits with copies of A's top bit. For W=32, 0x92345678 shifted by 8 gives 0xFF923456.
- R7: Operation code 8 returns 1 when A < B as two's-complement numbers, else 0. For W=32, A=0xFFFFFFFF with B=1 returns 1.
- R8: Operation code 9 returns 1 when A < B as unsigned numbers, else 0. For W=32, A=0xFFFFFFFF with B=1 returns 0.
- R9: Operation code 10 returns the low half of B placed in the upper half of the result, with the lower half cleared.
- R10: Operation codes 11 to 15 return zero.
- R11: The zero flag is high exactly when the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 nor, 5 sll, 6 srl, 7 sra, 8 slt, 9 sltu, 10 upper-half load) |
| opnd_a | input | W (32) | First operand; the value shifted by shift operations |
| opnd_b | input | W (32) | Second operand; its low half is the constant for code 10 |
| shamt | input | $clog2(W) (5) | Shift count |
| result | output | W (32) | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds the unit at its default width of 32, which makes the shift count 5 bits wide. At that width every shift distance from 0 to 31 can be reached, and the signed and unsigned comparisons meet at the 0x7FFFFFFF/0x80000000 and 0xFFFFFFFF/1 boundaries. At this width the stated numeric examples, such as the arithmetic shift of 0x92345678 by 8, apply literally. Random operands are biased toward sign-boundary values, so that wraparound, sign fill and the comparison split are all exercised.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W),
  localparam int HALF = W / 2
) (
  input  logic [3:0]      op_sel,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [SH_W-1:0] shamt,
  output logic [W-1:0]    result,
  output logic            zero
);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_NOR  = 4'd4;
  localparam logic [3:0] OP_SLL  = 4'd5;
  localparam logic [3:0] OP_SRL  = 4'd6;
  localparam logic [3:0] OP_SRA  = 4'd7;
  localparam logic [3:0] OP_SLT  = 4'd8;
  localparam logic [3:0] OP_SLTU = 4'd9;
  localparam logic [3:0] OP_LUI  = 4'd10;

  logic         sub_mode;
  logic [W:0]   sum_ext;
  logic         less_u, less_s;

  assign sub_mode = (op_sel == OP_SUB) || (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign sum_ext  = {1'b0, opnd_a} + {1'b0, opnd_b ^ {W{sub_mode}}} + {{W{1'b0}}, sub_mode};
  assign less_u   = ~sum_ext[W];
  assign less_s   = (opnd_a[W-1] ^ opnd_b[W-1]) ? opnd_a[W-1] : sum_ext[W-1];

  logic         left_mode, fill_bit;
  logic [W-1:0] a_rev, sh_in, sh_out, out_rev, shifted;
  logic [W-1:0] stg [0:SH_W];

  assign left_mode = (op_sel == OP_SLL);
  assign fill_bit  = (op_sel == OP_SRA) & opnd_a[W-1];

  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign a_rev[i]   = opnd_a[W-1-i];
    assign out_rev[i] = sh_out[W-1-i];
  end

  assign sh_in  = left_mode ? a_rev : opnd_a;
  assign stg[0] = sh_in;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = shamt[s] ? {{D{fill_bit}}, stg[s][W-1:D]} : stg[s];
  end

  assign sh_out  = stg[SH_W];
  assign shifted = left_mode ? out_rev : sh_out;

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: result = sum_ext[W-1:0];
      OP_AND:         result = opnd_a & opnd_b;
      OP_OR:          result = opnd_a | opnd_b;
      OP_NOR:         result = ~(opnd_a | opnd_b);
      OP_SLL, OP_SRL,
      OP_SRA:         result = shifted;
      OP_SLT:         result = {{(W-1){1'b0}}, less_s};
      OP_SLTU:        result = {{(W-1){1'b0}}, less_u};
      OP_LUI:         result = {opnd_b[HALF-1:0], {HALF{1'b0}}};
      default:        result = '0;
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    if (op_sel == OP_ADD && opnd_b == '0)
      a_r1_add_identity: assert (result == opnd_a);
    if (op_sel == OP_SUB && opnd_a == opnd_b)
      a_r2_sub_self_zero: assert (zero);
    if (op_sel == OP_SLL)
      a_r5_sll_low_clear: assert ((result & ((W'(1) << shamt) - W'(1))) == '0);
    if (op_sel == OP_SRA && opnd_a[W-1])
      a_r6_sra_sign_kept: assert (result[W-1]);
    if (op_sel == OP_SLT || op_sel == OP_SLTU)
      a_r7_r8_flag_only: assert (result[W-1:1] == '0);
    if (op_sel == OP_LUI)
      a_r9_lui_low_clear: assert (result[HALF-1:0] == '0);
    if (op_sel > OP_LUI)
      a_r10_unused_zero: assert (result == '0 && zero);
  end

endmodule

// File: tb/tb_int_alu.sv
module tb_int_alu;
  localparam int W = 32;
  localparam int SH_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]      op_sel;
  logic [W-1:0]    opnd_a, opnd_b;
  logic [SH_W-1:0] shamt;
  logic [W-1:0]    result;
  logic            zero;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int_alu #(.W(W)) dut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shamt(shamt), .result(result), .zero(zero)
  );

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [SH_W-1:0] sh);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return ~(a | b);
      4'd5:  return a << sh;
      4'd6:  return a >> sh;
      4'd7:  return W'($signed(a) >>> sh);
      4'd8:  return ($signed(a) < $signed(b)) ? W'(1) : W'(0);
      4'd9:  return (a < b) ? W'(1) : W'(0);
      4'd10: return {b[15:0], 16'h0000};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";  4'd1: return "R2";
      4'd2, 4'd3: return "R3";  4'd4: return "R4";
      4'd5, 4'd6: return "R5";  4'd7: return "R6";
      4'd8: return "R7";  4'd9: return "R8";
      4'd10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [SH_W-1:0] sh);
    logic [W-1:0] exp;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
    #1;
    exp = model(op, a, b, sh);
    check(result === exp, tag_of(op), result, exp);
    check(zero === (exp == '0), "R11", W'(zero), W'(exp == '0));
  endtask

  function automatic logic [W-1:0] pick();
    case ($urandom % 8)
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0001;
      4: return 32'h0000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    op_sel = 4'd0; opnd_a = '0; opnd_b = '0; shamt = '0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: idle inputs give a zero result with the flag set (R1, R11)
    @(negedge clk); #1;
    check(result === '0, "R1", result, '0);
    check(zero === 1'b1, "R11", W'(zero), W'(1));

    run(4'd0, 32'hFFFF_FFFF, 32'h1, 0);          // R1 wrap to zero
    run(4'd0, 32'h7FFF_FFFF, 32'h1, 0);          // R1 sign boundary
    run(4'd1, 32'h0, 32'h1, 0);                  // R2 wrap
    run(4'd1, 32'h1234_5678, 32'h1234_5678, 0);  // R2 self, R11
    run(4'd2, 32'h3C00, 32'hDC0, 0);             // R3
    run(4'd3, 32'h3C00, 32'hDC0, 0);             // R3
    run(4'd4, 32'h3C00, 32'h0, 0);               // R4 complement
    run(4'd4, 32'hFFFF_FFFF, 32'h0, 0);          // R4 to zero
    run(4'd5, 32'h1234_5678, 0, 8);              // R5
    run(4'd5, 32'hFFFF_FFFF, 0, 31);             // R5 max
    run(4'd6, 32'h8000_0001, 0, 31);             // R5 max
    run(4'd6, 32'hDEAD_BEEF, 0, 0);              // R5 zero count
    run(4'd7, 32'h9234_5678, 0, 8);              // R6 example
    run(4'd7, 32'h8000_0000, 0, 31);             // R6 full fill
    run(4'd7, 32'h1234_5678, 0, 8);              // R6 positive
    run(4'd8, 32'hFFFF_FFFF, 32'h1, 0);          // R7
    run(4'd8, 32'h7FFF_FFFF, 32'h8000_0000, 0);  // R7
    run(4'd9, 32'hFFFF_FFFF, 32'h1, 0);          // R8
    run(4'd9, 32'h7FFF_FFFF, 32'h8000_0000, 0);  // R8
    run(4'd10, 32'hFFFF_FFFF, 32'hABCD_1234, 0); // R9
    for (int c = 11; c < 16; c++) run(4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31); // R10

    for (int i = 0; i < 3000; i++)
      run(4'($urandom % 16), pick(), pick(), 5'($urandom));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule